// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an 8K x 8 asynchronous static RAM. The host asks for one byte at a time. The block turns each request into a timed pattern on the chip-enable, output-enable and write-enable strobes. It also drives the 13-bit address and the 8-bit write data for the RAM. All strobes are active low. Every minimum time in nanoseconds is turned into a whole number of clock cycles when the design is elaborated. A phase counter holds each strobe phase for that many cycles.

The host side is a simple request handshake. When `ready` is high, a `req` pulse on a clock edge is taken together with its direction, address and data. `ready` stays low until the RAM cycle, including its recovery time, is complete. A read returns its byte on `rdata` with a one-cycle `rvalid` pulse. A write is opened by the later of the two falling strobes, which is always write-enable, one cycle after chip-enable. It is closed by the earlier rising strobe, which is always write-enable, before chip-enable. So the write window is the span in which both strobes are low.

Each strobe is registered, so the pins never glitch. The whole block is reset by a synchronous active-high reset.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it is sampled high, all three strobes are high, `sram_dq_oe` is low and `rvalid` is low. After the first reset edge `ready` is high. A reset in the middle of a cycle aborts that cycle.
- R2: A request is taken only on an edge where `req` and `ready` are both high. `ready` is low on the cycle that follows. While `ready` is low, `req` and the request fields have no effect: the RAM address does not change and no extra cycle is run.
- R3: A read holds chip-enable and output-enable low and write-enable high. The byte is sampled on the last edge of the access phase. That phase lasts the largest of the address, chip-enable and output-enable access times, in cycles. The byte appears on `rdata` with `rvalid` high for exactly one cycle, the same cycle in which `ready` returns high.
- R4: In a write, chip-enable falls one cycle before write-enable. Write-enable rises while chip-enable is still low. Write-enable stays low for at least max(pulse width, data setup) cycles.
- R5: `sram_dq_oe` is high on every cycle in which both chip-enable and write-enable are low. The write data is stable over that time, and output-enable is high. The data stays driven and unchanged for the hold time in cycles after write-enable rises. `sram_dq_oe` is never high while output-enable is low.
- R6: `sram_addr` does not change while chip-enable is low.
- R7: Write-enable stays high for at least the recovery time in cycles after a write, before chip-enable falls for the next cycle.
- R8: Each time T ns becomes max(1, ceil(T / clock period)) cycles. A read keeps `ready` low for AS + max(ACC, RC - AS) cycles. A write keeps it low for AS + 1 + WPX + DH + WR cycles, where WPX = max(WP, DS, WC - AS - 1 - DH, 1). With the defaults and a 20 ns clock, both are 9 cycles.
- R9: All 13 address bits reach the RAM. The lowest address 0 and the highest address 8191 can each be written and read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken when `ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Idle and able to take a request |
| rvalid | output | 1 | One-cycle pulse: `rdata` holds a read result |
| rdata | output | 8 | Read result |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_addr | output | 13 | RAM address |
| sram_dq_out | output | 8 | Write data toward the RAM data pins |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_in | input | 8 | Data returned from the RAM data pins |

## Verification
The embedded properties check the strobe order on every cycle:
- chip-enable leads write-enable;
- write-enable rises first;
- the write pulse width, the data hold after the closing edge and the write-enable recovery gap are met;
- the address is frozen while the chip is selected, and the address is also frozen while busy;
- `rvalid` is a single-cycle pulse.

Only the bench scenarios can show the rest:
- a read returns the correct byte at the correct edge, which needs a RAM model that withholds data until the access time has passed;
- written bytes really land at the extreme addresses;
- requests made while busy are dropped;
- the busy length matches the cycle counts derived from the nanosecond parameters.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RD_ACT,
        ST_WR_CE,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_WR_REC
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_s;

    localparam strobe_s STB_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    // Whole cycles covering a time in ns, never less than one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin pattern held during each phase.
    function automatic strobe_s phase_strobes(input seq_state_e st);
        strobe_s s;
        s = STB_QUIET;
        case (st)
            ST_RD_ACT:   begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
            ST_WR_CE:    begin s.ce_n = 1'b0; end
            ST_WR_PULSE: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.dq_oe = 1'b1; end
            ST_WR_HOLD:  begin s.ce_n = 1'b0; s.dq_oe = 1'b1; end
            default:     s = STB_QUIET;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val - 1'b1;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);

    // R8: a phase is never given zero length
    p_load_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    parameter int AS_C   = 1,
    parameter int RD_C   = 8,
    parameter int WP_C   = 5,
    parameter int DH_C   = 1,
    parameter int WR_C   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              t_last,
    output logic              t_load,
    output logic [CNT_W-1:0]  t_val,
    output logic              ready,
    output logic              capture,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              dq_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    typedef struct packed {
        seq_state_e        st;
        strobe_s           stb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
    } fsm_s;

    fsm_s r_q, r_d;

    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_val  = CNT_W'(1);
        case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.wr    = req_we;
                    r_d.st    = ST_SETUP;
                    t_load    = 1'b1;
                    t_val     = CNT_W'(AS_C);
                end
            end
            ST_SETUP: begin
                if (t_last) begin
                    t_load = 1'b1;
                    if (r_q.wr) begin
                        r_d.st = ST_WR_CE;
                        t_val  = CNT_W'(1);
                    end else begin
                        r_d.st = ST_RD_ACT;
                        t_val  = CNT_W'(RD_C);
                    end
                end
            end
            ST_RD_ACT: begin
                if (t_last) r_d.st = ST_IDLE;
            end
            ST_WR_CE: begin
                if (t_last) begin
                    r_d.st = ST_WR_PULSE;
                    t_load = 1'b1;
                    t_val  = CNT_W'(WP_C);
                end
            end
            ST_WR_PULSE: begin
                if (t_last) begin
                    r_d.st = ST_WR_HOLD;
                    t_load = 1'b1;
                    t_val  = CNT_W'(DH_C);
                end
            end
            ST_WR_HOLD: begin
                if (t_last) begin
                    r_d.st = ST_WR_REC;
                    t_load = 1'b1;
                    t_val  = CNT_W'(WR_C);
                end
            end
            ST_WR_REC: begin
                if (t_last) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.stb = phase_strobes(r_d.st);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= ST_IDLE;
            r_q.stb   <= STB_QUIET;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
            r_q.wr    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready     = (r_q.st == ST_IDLE);
    assign capture   = (r_q.st == ST_RD_ACT) && t_last;
    assign ce_n      = r_q.stb.ce_n;
    assign oe_n      = r_q.stb.oe_n;
    assign we_n      = r_q.stb.we_n;
    assign dq_oe     = r_q.stb.dq_oe;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;

    // Assertion support: width of the write pulse and the gap since it ended
    logic [CNT_W:0] wp_cnt_q;
    logic [CNT_W:0] rec_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_cnt_q  <= '0;
            rec_cnt_q <= (CNT_W+1)'(WR_C);
        end else begin
            wp_cnt_q <= we_n ? '0 : wp_cnt_q + 1'b1;
            if (!we_n)
                rec_cnt_q <= '0;
            else if (rec_cnt_q < (CNT_W+1)'(WR_C))
                rec_cnt_q <= rec_cnt_q + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ready |-> (ce_n && we_n && oe_n && !dq_oe));

    p_busy_holds_addr_r2: assert property (@(posedge clk) disable iff (rst)
        !ready |=> $stable(mem_addr));

    p_ce_leads_we_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> $past(!ce_n));

    p_we_closes_first_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_n) |-> $past(we_n));

    p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (wp_cnt_q >= (CNT_W+1)'(WP_C)));

    p_hold_after_close_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (dq_oe && $stable(mem_wdata)));

    p_no_drive_when_oe_r5: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !dq_oe);

    p_addr_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> $stable(mem_addr));

    p_recovery_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ce_n) |-> (rec_cnt_q >= (CNT_W+1)'(WR_C)));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_s;

    cap_s c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.valid = capture;
        if (capture) c_d.data = dq_in;
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign rvalid = c_q.valid;
    assign rdata  = c_q.data;

    p_rvalid_single_r3: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_AS_NS       = 0,
    parameter int T_ACC_NS      = 150,
    parameter int T_CO_NS       = 150,
    parameter int T_OE_NS       = 70,
    parameter int T_RC_NS       = 150,
    parameter int T_WC_NS       = 150,
    parameter int T_WP_NS       = 90,
    parameter int T_DS_NS       = 50,
    parameter int T_DH_NS       = 10,
    parameter int T_WR_NS       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int AS_C  = ns_to_cyc(T_AS_NS, CLK_PERIOD_NS);
    localparam int ACC_C = max2(max2(ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_CO_NS, CLK_PERIOD_NS)),
                                ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
    localparam int RC_C  = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int WC_C  = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int DH_C  = ns_to_cyc(T_DH_NS, CLK_PERIOD_NS);
    localparam int WR_C  = ns_to_cyc(T_WR_NS, CLK_PERIOD_NS);
    localparam int RD_C  = max2(ACC_C, max2(RC_C - AS_C, 1));
    localparam int WP_C  = max2(max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(T_DS_NS, CLK_PERIOD_NS)),
                                max2(WC_C - AS_C - 1 - DH_C, 1));
    localparam int MAX_C = max2(max2(AS_C, RD_C), max2(max2(WP_C, DH_C), WR_C));
    localparam int CNT_W = $clog2(MAX_C + 1);

    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_last;
    logic             capture;

    sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    sram_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .AS_C   (AS_C),
        .RD_C   (RD_C),
        .WP_C   (WP_C),
        .DH_C   (DH_C),
        .WR_C   (WR_C)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .t_last    (t_last),
        .t_load    (t_load),
        .t_val     (t_val),
        .ready     (ready),
        .capture   (capture),
        .ce_n      (sram_ce_n),
        .oe_n      (sram_oe_n),
        .we_n      (sram_we_n),
        .dq_oe     (sram_dq_oe),
        .mem_addr  (sram_addr),
        .mem_wdata (sram_dq_out)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .dq_in   (sram_dq_in),
        .rvalid  (rvalid),
        .rdata   (rdata)
    );

endmodule

// File: tb/sim_sram_strobe_ctrl.sv
module sim_sram_strobe_ctrl;

    localparam int CLK_NS = 20;
    localparam int T_AS = 0, T_ACC = 150, T_CO = 150, T_OE = 70, T_RC = 150;
    localparam int T_WC = 150, T_WP = 90, T_DS = 50, T_DH = 10, T_WR = 10;

    function int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected cycle counts, from R8
    localparam int B_AS  = cyc(T_AS);
    localparam int B_ACC = mx(mx(cyc(T_ACC), cyc(T_CO)), cyc(T_OE));
    localparam int B_DH  = cyc(T_DH);
    localparam int B_WR  = cyc(T_WR);
    localparam int B_WP  = mx(mx(cyc(T_WP), cyc(T_DS)), mx(cyc(T_WC) - B_AS - 1 - B_DH, 1));
    localparam int R_BUSY = B_AS + mx(B_ACC, mx(cyc(T_RC) - B_AS, 1));
    localparam int W_BUSY = B_AS + 1 + B_WP + B_DH + B_WR;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rvalid;
    logic [7:0]  rdata;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [12:0] sram_addr;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in = 8'hEE;

    always #(CLK_NS/2) clk = ~clk;

    sram_strobe_ctrl #(
        .CLK_PERIOD_NS(CLK_NS), .T_AS_NS(T_AS), .T_ACC_NS(T_ACC), .T_CO_NS(T_CO),
        .T_OE_NS(T_OE), .T_RC_NS(T_RC), .T_WC_NS(T_WC), .T_WP_NS(T_WP),
        .T_DS_NS(T_DS), .T_DH_NS(T_DH), .T_WR_NS(T_WR)
    ) u0 (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .rvalid(rvalid), .rdata(rdata),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, expv, $time);
        end
    endtask

    // ---------------- behavioural RAM with strobe-order checks ----------------
    logic [7:0] ram [int];
    int         rd_cnt, win_cnt, hold_left, rec_cnt;
    bit         win;
    logic [7:0] win_data;
    logic       prev_ce_n;
    logic [12:0] prev_addr;

    function logic [7:0] ram_rd(input int a);
        return ram.exists(a) ? ram[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            rd_cnt <= 0; win <= 0; win_cnt <= 0; hold_left <= 0; rec_cnt <= 1000;
            prev_ce_n <= 1'b1; prev_addr <= sram_addr;
        end else begin
            if (!sram_ce_n && !sram_oe_n && sram_we_n) rd_cnt <= rd_cnt + 1;
            else rd_cnt <= 0;
            if (!sram_ce_n && !prev_ce_n)
                chk(sram_addr == prev_addr, "R6 address moved while selected", sram_addr, prev_addr);
            if (!sram_ce_n && prev_ce_n) begin
                chk(sram_we_n, "R4 chip enable must fall before write enable", sram_we_n, 1);
                chk(rec_cnt >= B_WR, "R7 write recovery gap", rec_cnt, B_WR);
            end
            if (!sram_we_n) rec_cnt <= 0; else rec_cnt <= rec_cnt + 1;
            if (!sram_ce_n && !sram_we_n) begin
                chk(sram_dq_oe && sram_oe_n, "R5 drive on and OE high in window",
                    {sram_dq_oe, sram_oe_n}, 3);
                if (win) chk(sram_dq_out == win_data, "R5 data stable in window", sram_dq_out, win_data);
                win <= 1; win_cnt <= win_cnt + 1; win_data <= sram_dq_out;
            end else if (win) begin
                win <= 0; win_cnt <= 0;
                chk(!sram_ce_n, "R4 write enable must rise first", sram_ce_n, 0);
                chk(win_cnt >= B_WP, "R4 write pulse width", win_cnt, B_WP);
                chk(sram_dq_oe && sram_dq_out == win_data, "R5 data hold after close",
                    sram_dq_out, win_data);
                ram[int'(prev_addr)] = win_data;
                hold_left <= B_DH - 1;
            end else if (hold_left > 0) begin
                chk(sram_dq_oe && sram_dq_out == win_data, "R5 data hold after close",
                    sram_dq_out, win_data);
                hold_left <= hold_left - 1;
            end
            prev_ce_n <= sram_ce_n;
            prev_addr <= sram_addr;
        end
    end

    // data is valid only once the access time has elapsed
    always @(negedge clk) begin
        if (!sram_ce_n && !sram_oe_n && sram_we_n && rd_cnt >= B_ACC - 1)
            sram_dq_in = ram_rd(int'(sram_addr));
        else
            sram_dq_in = 8'hEE;
    end

    // ---------------- cycle-by-cycle reference model ----------------
    logic [7:0] ref_mem [int];
    int         busy;
    bit         pend_rd, exp_rvalid;
    logic [7:0] pend_data, exp_rdata;

    always @(posedge clk) begin
        if (rst) begin
            busy <= 0; pend_rd <= 0; exp_rvalid <= 0;
        end else begin
            exp_rvalid <= 0;
            if (busy == 0) begin
                if (req) begin
                    if (req_we) begin
                        busy <= W_BUSY; pend_rd <= 0;
                        ref_mem[int'(req_addr)] = req_wdata;
                    end else begin
                        busy <= R_BUSY; pend_rd <= 1;
                        pend_data <= ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 8'h00;
                    end
                end
            end else begin
                busy <= busy - 1;
                if (busy == 1 && pend_rd) begin
                    exp_rvalid <= 1; exp_rdata <= pend_data;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(ready == (busy == 0), "R2 R8 ready vs model", ready, busy == 0);
            chk(rvalid == exp_rvalid, "R3 rvalid vs model", rvalid, exp_rvalid);
            if (exp_rvalid) chk(rdata == exp_rdata, "R3 R9 read data", rdata, exp_rdata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_ready();
        do @(negedge clk); while (!ready);
    endtask

    task automatic issue(input bit we, input logic [12:0] a, input logic [7:0] d);
        wait_ready();
        req = 1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 0; req_we = ~we; req_addr = ~a; req_wdata = ~d;
    endtask

    task automatic measure_busy(input bit we, input logic [12:0] a, input int expv, input string tag);
        int n;
        issue(we, a, 8'h3C);
        n = 1;
        while (!ready) begin @(negedge clk); n++; end
        chk(n - 1 == expv, tag, n - 1, expv);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rvalid && ready,
            "R1 reset state", {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, rvalid, ready}, 6'b111001);
        repeat (2) @(negedge clk);
        rst = 0;

        // boundary addresses, R9
        issue(1, 13'h0000, 8'hA5);
        issue(1, 13'h1FFF, 8'h5A);
        issue(0, 13'h0000, 8'h00);
        issue(0, 13'h1FFF, 8'h00);
        issue(1, 13'h0AAA, 8'hFF);
        issue(1, 13'h1555, 8'h00);
        issue(0, 13'h0AAA, 8'h00);
        issue(0, 13'h1555, 8'h00);

        // R8 explicit busy lengths
        measure_busy(1, 13'h0042, W_BUSY, "R8 write busy length");
        measure_busy(0, 13'h0042, R_BUSY, "R8 read busy length");

        // R2 requests while busy are ignored
        issue(1, 13'h0100, 8'h11);
        issue(0, 13'h0100, 8'h00);
        req = 1; req_we = 1; req_addr = 13'h0100; req_wdata = 8'h99;
        repeat (3) @(negedge clk);
        req = 0;
        issue(0, 13'h0100, 8'h00);
        wait_ready();
        @(negedge clk);
        chk(rdata == 8'h11, "R2 write while busy was ignored", rdata, 8'h11);

        // R2 R3 back-to-back with req held high
        for (int k = 0; k < 6; k++) begin
            wait_ready();
            req = 1; req_we = (k < 3); req_addr = 13'h0200 + 13'(k % 3);
            req_wdata = 8'(8'h20 + k);
        end
        @(negedge clk);
        req = 0;
        wait_ready();

        // R1 reset in the middle of a write
        issue(1, 13'h0777, 8'h77);
        repeat (2) @(negedge clk);
        rst = 1;
        @(negedge clk);
        chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R1 reset aborts write",
            {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(ready, "R1 ready after reset", ready, 1);
        issue(1, 13'h0003, 8'hC3);
        issue(0, 13'h0003, 8'h00);
        wait_ready();
        repeat (3) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R2 run did not complete actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule